// File: doc/BRIEF.md
# Four-Channel 56-Bit Countdown Timer

This peripheral holds four independent countdown channels behind a plain 32-bit register bus: an address, a write strobe, write data and read data that follows the address combinationally. Each channel keeps a 56-bit interval and a 56-bit current count. Each 56-bit value is exposed as a low word and a 24-bit high word. A channel decrements once per prescaled tick while it runs. When it reaches zero it either restarts from its interval or stops, depending on its mode.

A channel flags expiry in a shared pending register. Software clears pending bits by writing ones to them. A shared enable register selects which pending bits drive the single interrupt line. A common use loads the interval with all ones and starts a channel with a reload. The inverted low word of the current count then serves as a rising 32-bit timestamp.

Top module: `qct_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The interrupt enable register is at 0x00 and the pending register is at 0x04, with bit n of each belonging to channel n. Channel n has five registers starting at 0x10 + 0x20·n: control at +0x0, interval low at +0x4, interval high at +0x8, current low at +0xC and current high at +0x10. Every other address reads zero.
- R3: The control register fields are: bit 0 run, bit 1 reload strobe, bits 6:4 prescale select k, and bit 7 mode (0 periodic, 1 one-shot). The reload bit always reads 0. All other bits read 0.
- R4: A control write with bit 1 set copies the full 56-bit interval into the current count on that clock edge.
- R5: While run is set, a tick occurs every 2^k clocks. The first tick falls on the 2^k-th edge after the control write. The count decrements by one per tick, and it is held while run is clear.
- R6: A tick with the count at zero sets the channel's pending bit. In periodic mode that tick also reloads the count from the interval.
- R7: In one-shot mode, a tick at zero clears the channel's run bit and leaves the count at zero.
- R8: A write to the pending register clears each bit written as 1 and leaves bits written as 0 unchanged. A pending bit is never cleared in any other way. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some channel has both its pending bit and its enable bit set. With the enable register at zero, `irq` stays low while pending bits remain readable.
- R10: The high interval word and the high current word hold 24 bits, and bits 31:24 read zero. Writes to the current-count registers have no effect.
- R11: With the interval set to all ones and a control write of 0x3, the inverted current low word increases by one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The countdown is tried in four patterns:
- A free-running all-ones interval at prescale 0. This separates a correct decrement and timestamp from an off-by-one in the first tick.
- A short periodic interval. This shows whether the count reloads at zero and whether pending bits repeat.
- A one-shot interval at prescale 2. This separates stopping from wrapping.
- A prescale of 7 sampled on the 127th and 128th edge after the start. This exposes a wrong tick period by a single cycle.

Clear-by-writing-zero, masked interrupts, a reload without run, and writes to read-only or truncated words each check that only the intended state moves.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int DATA_W     = 32;
  localparam int PS_W       = 3;
  localparam int OFS_IEN    = 'h00;
  localparam int OFS_PEND   = 'h04;
  localparam int CH_BASE    = 'h10;
  localparam int CH_STRIDE  = 'h20;
  localparam int SUB_CTRL   = 'h00;
  localparam int SUB_IVL_LO = 'h04;
  localparam int SUB_IVL_HI = 'h08;
  localparam int SUB_CUR_LO = 'h0C;
  localparam int SUB_CUR_HI = 'h10;
  localparam int BIT_RUN    = 0;
  localparam int BIT_RELOAD = 1;
  localparam int BIT_PS_LO  = 4;
  localparam int BIT_MODE   = 7;

  typedef struct packed {
    logic            oneshot;
    logic [PS_W-1:0] psel;
    logic            run;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w                     = '0;
    w[BIT_RUN]            = c.run;
    w[BIT_PS_LO +: PS_W]  = c.psel;
    w[BIT_MODE]           = c.oneshot;
    return w;
  endfunction
endpackage

// File: rtl/qct_prescale.sv
module qct_prescale
  import qct_pkg::*;
#(
  parameter int SEL_W = PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask  = ~({CW{1'b1}} << sel);
    tick  = run && !restart && ((cnt_q & mask) == mask);
    cnt_d = (run && !restart) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int CNT_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ivl_lo_wr,
  input  logic              ivl_hi_wr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  ivl,
  output logic [CNT_W-1:0]  cur,
  output logic              expire
);
  localparam int HI_W = CNT_W - DATA_W;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ivl_q, ivl_d, cur_q, cur_d;
  logic             tick, at_zero, ctrl_ce, ivl_ce, cur_ce;

  qct_prescale #(.SEL_W(PS_W)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (ctrl_wr),
    .sel     (ctrl_q.psel),
    .tick    (tick)
  );

  always_comb begin
    at_zero = (cur_q == '0);
    expire  = tick && at_zero;

    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run     = wdata[BIT_RUN];
      ctrl_d.psel    = wdata[BIT_PS_LO +: PS_W];
      ctrl_d.oneshot = wdata[BIT_MODE];
    end else if (expire && ctrl_q.oneshot) begin
      ctrl_d.run = 1'b0;
    end
    ctrl_ce = ctrl_wr || expire;

    ivl_d = ivl_q;
    if (ivl_lo_wr) ivl_d[DATA_W-1:0]     = wdata;
    if (ivl_hi_wr) ivl_d[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
    ivl_ce = ivl_lo_wr || ivl_hi_wr;

    cur_d = cur_q;
    if (ctrl_wr && wdata[BIT_RELOAD]) cur_d = ivl_q;
    else if (tick && !at_zero)        cur_d = cur_q - 1'b1;
    else if (expire && !ctrl_q.oneshot) cur_d = ivl_q;
    cur_ce = (ctrl_wr && wdata[BIT_RELOAD]) || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ivl_q  <= '0;
      cur_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (ivl_ce)  ivl_q  <= ivl_d;
      if (cur_ce)  cur_q  <= cur_d;
    end
  end

  assign ctrl = ctrl_q;
  assign ivl  = ivl_q;
  assign cur  = cur_q;
endmodule

// File: rtl/qct_top.sv
module qct_top
  import qct_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 56,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;

  ctrl_t [NCH-1:0]            ctrl_v;
  logic  [NCH-1:0][CNT_W-1:0] ivl_v, cur_v;
  logic  [NCH-1:0]            expire_v, ctrl_wr_v, lo_wr_v, hi_wr_v, run_v;
  logic  [NCH-1:0]            ien_q, ien_d, pend_q, pend_d;
  logic                       ien_wr, pend_wr;

  assign ien_wr  = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
  assign pend_wr = bus_we && (bus_addr == ADDR_W'(OFS_PEND));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * ch;
    assign ctrl_wr_v[ch] = bus_we && (bus_addr == ADDR_W'(BASE + SUB_CTRL));
    assign lo_wr_v[ch]   = bus_we && (bus_addr == ADDR_W'(BASE + SUB_IVL_LO));
    assign hi_wr_v[ch]   = bus_we && (bus_addr == ADDR_W'(BASE + SUB_IVL_HI));
    assign run_v[ch]     = ctrl_v[ch].run;

    qct_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr_v[ch]),
      .ivl_lo_wr (lo_wr_v[ch]),
      .ivl_hi_wr (hi_wr_v[ch]),
      .wdata     (bus_wdata),
      .ctrl      (ctrl_v[ch]),
      .ivl       (ivl_v[ch]),
      .cur       (cur_v[ch]),
      .expire    (expire_v[ch])
    );
  end

  always_comb begin
    ien_d  = ien_wr ? bus_wdata[NCH-1:0] : ien_q;
    pend_d = pend_q;
    if (pend_wr) pend_d = pend_d & ~bus_wdata[NCH-1:0];
    pend_d = pend_d | expire_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ien_wr) ien_q <= ien_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata[NCH-1:0] = ien_q;
    if (bus_addr == ADDR_W'(OFS_PEND)) bus_rdata[NCH-1:0] = pend_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CTRL))
        bus_rdata = ctrl_word(ctrl_v[c]);
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_IVL_LO))
        bus_rdata = ivl_v[c][DATA_W-1:0];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_IVL_HI))
        bus_rdata = DATA_W'(ivl_v[c][CNT_W-1:DATA_W]);
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CUR_LO))
        bus_rdata = cur_v[c][DATA_W-1:0];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CUR_HI))
        bus_rdata = DATA_W'(cur_v[c][CNT_W-1:DATA_W]);
    end
  end

  assign irq = |(pend_q & ien_q);
endmodule

// File: rtl/qct_checker.sv
module qct_checker
  import qct_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 56,
  parameter int ADDR_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_we,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       irq,
  input logic [NCH-1:0]             ien,
  input logic [NCH-1:0]             pend,
  input logic [NCH-1:0][CNT_W-1:0]  cur,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             ctrl_wr
);
  localparam int HI_W = CNT_W - DATA_W;

  logic pend_wr, hi_sel;
  always_comb begin
    pend_wr = bus_we && (bus_addr == ADDR_W'(OFS_PEND)) && (bus_wdata[NCH-1:0] != '0);
    hi_sel  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_IVL_HI)) hi_sel = 1'b1;
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + SUB_CUR_HI)) hi_sel = 1'b1;
    end
  end

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend & $past(pend)) == $past(pend)));

  assert_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_sel |-> (bus_rdata[DATA_W-1:HI_W] == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !ctrl_wr[c]) |=> $stable(cur[c]));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !ctrl_wr[c] && (cur[c] != '0)) |=>
        ((cur[c] == $past(cur[c])) || (cur[c] == $past(cur[c]) - CNT_W'(1))));
  end
endmodule

bind qct_top qct_checker #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ien       (ien_q),
  .pend      (pend_q),
  .cur       (cur_v),
  .run       (run_v),
  .ctrl_wr   (ctrl_wr_v)
);

// File: tb/qct_top_tb.sv
module qct_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qct_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // behavioural reference state
  logic [55:0] m_ivl [4];
  logic [55:0] m_cur [4];
  bit          m_run [4];
  bit          m_one [4];
  int          m_ps  [4];
  int          m_pc  [4];
  logic [3:0]  m_ien, m_pend;

  function automatic logic [31:0] m_read(logic [7:0] a);
    int ai;
    ai = int'(a);
    if (ai == 0) return {28'b0, m_ien};
    if (ai == 4) return {28'b0, m_pend};
    for (int c = 0; c < 4; c++) begin
      int off;
      off = ai - (16 + 32 * c);
      if (off == 0)  return {24'b0, m_one[c], 3'(m_ps[c]), 3'b0, m_run[c]};
      if (off == 4)  return m_ivl[c][31:0];
      if (off == 8)  return {8'b0, m_ivl[c][55:32]};
      if (off == 12) return m_cur[c][31:0];
      if (off == 16) return {8'b0, m_cur[c][55:32]};
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_ivl[c] = '0; m_cur[c] = '0; m_run[c] = 0; m_one[c] = 0;
        m_ps[c] = 0; m_pc[c] = 0;
      end
      m_ien = '0; m_pend = '0;
    end else begin
      logic [3:0] newp;
      newp = '0;
      for (int c = 0; c < 4; c++) begin
        int base, mask;
        bit cw, tk, ex;
        base = 16 + 32 * c;
        mask = (1 << m_ps[c]) - 1;
        cw = bus_we && (int'(bus_addr) == base);
        tk = m_run[c] && !cw && ((m_pc[c] & mask) == mask);
        m_pc[c] = (m_run[c] && !cw) ? m_pc[c] + 1 : 0;
        ex = tk && (m_cur[c] == 0);
        if (cw && bus_wdata[1]) m_cur[c] = m_ivl[c];
        else if (tk) begin
          if (m_cur[c] != 0) m_cur[c] = m_cur[c] - 1;
          else if (!m_one[c]) m_cur[c] = m_ivl[c];
        end
        if (cw) begin
          m_run[c] = bus_wdata[0];
          m_ps[c]  = int'(bus_wdata[6:4]);
          m_one[c] = bus_wdata[7];
        end else if (ex && m_one[c]) m_run[c] = 0;
        if (ex) newp[c] = 1'b1;
        if (bus_we && int'(bus_addr) == base + 4) m_ivl[c][31:0]  = bus_wdata;
        if (bus_we && int'(bus_addr) == base + 8) m_ivl[c][55:32] = bus_wdata[23:0];
      end
      if (bus_we && bus_addr == 8'h04) m_pend = m_pend & ~bus_wdata[3:0];
      m_pend = m_pend | newp;
      if (bus_we && bus_addr == 8'h00) m_ien = bus_wdata[3:0];
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle interrupt comparison against the model (R9)
  bit mon_on = 0;
  always @(negedge clk) begin
    if (mon_on && rst_n) chk({31'b0, irq}, {31'b0, |(m_pend & m_ien)}, "R9 irq");
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    v = bus_rdata;
    chk(v, m_read(a), tag);
  endtask

  task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, tag, v);
    chk(v, exp, tag);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] v;
    rd(8'h00, tag, v);
    rd(8'h04, tag, v);
    for (int c = 0; c < 4; c++)
      for (int o = 0; o <= 16; o += 4) rd(8'(16 + 32 * c + o), tag, v);
    rd(8'h0C, tag, v);
    rd(8'hF0, tag, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] t1, t2, v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // R1: reset state
    rdx(8'h00, 32'h0, "R1 ien");
    rdx(8'h04, 32'h0, "R1 pend");
    rdx(8'h10, 32'h0, "R1 ctrl0");
    rdx(8'h7C, 32'h0, "R1 cur3");
    chk({31'b0, irq}, 32'h0, "R1 irq");
    sweep("R2 map after reset");

    // R11/R10/R3: free-running channel 0
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0003);
    rdx(8'h18, 32'h00FF_FFFF, "R10 ivl hi truncation");
    rdx(8'h10, 32'h0000_0001, "R3 reload reads zero");
    rdx(8'h20, 32'h00FF_FFFF, "R4 cur hi after reload");
    rd(8'h1C, "R11 cur lo", t1);
    repeat (5) @(negedge clk);
    rd(8'h1C, "R11 cur lo", t2);
    chk(~t2 - ~t1, 32'd6, "R11 timestamp step");

    // R6/R8/R9: periodic channel 1
    wr(8'h34, 32'd3);
    wr(8'h00, 32'h2);
    wr(8'h30, 32'h0000_0003);
    repeat (12) @(negedge clk);
    rd(8'h04, "R6 pend periodic", v);
    chk(v & 32'h2, 32'h2, "R6 pend bit1 set");
    rd(8'h3C, "R6 periodic reload", v);
    wr(8'h04, 32'h0);
    rd(8'h04, "R8 write zero keeps", v);
    chk(v & 32'h2, 32'h2, "R8 write zero keeps bit1");
    wr(8'h30, 32'h0);
    wr(8'h04, 32'h2);
    rdx(8'h04, 32'h0, "R8 write one clears");
    chk({31'b0, irq}, 32'h0, "R9 irq low after clear");

    // R9: masking
    wr(8'h00, 32'h0);
    wr(8'h30, 32'h0000_0003);
    repeat (10) @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R9 masked irq");
    rd(8'h04, "R9 pend visible when masked", v);
    chk(v & 32'h2, 32'h2, "R9 pend bit1 while masked");
    wr(8'h30, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h3C, "R5 held while stopped", t1);
    repeat (4) @(negedge clk);
    rdx(8'h3C, t1, "R5 held while stopped");
    wr(8'h04, 32'hF);

    // R7: one-shot channel 2, prescale 2
    wr(8'h54, 32'd2);
    wr(8'h00, 32'h4);
    wr(8'h50, 32'h0000_00A3);
    repeat (30) @(negedge clk);
    rdx(8'h50, 32'h0000_00A0, "R7 run cleared");
    rdx(8'h5C, 32'h0, "R7 count at zero");
    rd(8'h04, "R7 pend", v);
    chk(v & 32'h4, 32'h4, "R7 pend bit2 set");
    chk({31'b0, irq}, 32'h1, "R9 irq for channel 2");
    wr(8'h04, 32'h4);

    // R4: reload without run
    wr(8'h54, 32'h1234_5678);
    wr(8'h58, 32'h0000_00AB);
    wr(8'h50, 32'h0000_0002);
    rdx(8'h5C, 32'h1234_5678, "R4 reload low");
    rdx(8'h60, 32'h0000_00AB, "R4 reload high");
    rdx(8'h50, 32'h0, "R4 ctrl after reload-only");

    // R5: prescale 7 on channel 3
    wr(8'h74, 32'd5);
    wr(8'h70, 32'h0000_0073);
    repeat (126) @(negedge clk);
    rdx(8'h7C, 32'd5, "R5 before 128th edge");
    rdx(8'h7C, 32'd4, "R5 at 128th edge");

    // R10: read-only current, truncated high interval
    wr(8'h7C, 32'hDEAD_BEEF);
    rd(8'h7C, "R10 cur write ignored", v);
    chk(v, 32'd4, "R10 cur write ignored");
    wr(8'h80, 32'hFFFF_FFFF);
    rdx(8'h80, 32'h0, "R10 cur hi write ignored");
    wr(8'h38, 32'hFFFF_FFFF);
    rdx(8'h38, 32'h00FF_FFFF, "R10 ivl hi bits 31:24 zero");

    sweep("R2 map final");
    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule